// File: doc/BRIEF.md
# Context Sequencer with Pipeline Stage Activation

This block is the stand-alone sequencer that sits beside a multi-context reconfigurable array. It walks a small state table held in its own registers. Each cycle it tells the array three things: which configuration context to use, which of the control steps packed into that context is the live one, and, inside a modulo-scheduled loop, which pipeline stages are currently active. Branch decisions come from condition flags raised by the array. A stall line from the array freezes all sequencing.

A host loads the table through a simple register port while the sequencer is halted, and can read any entry back at any time. A start command launches execution at entry 0. A halt command stops it. Reaching an entry marked terminal stops it and raises a done flag.

A loop-mode entry runs a folded loop body. It takes DII consecutive contexts from a base number and issues a new iteration every DII cycles. During the prologue, stage enables are masked so that stages fill one at a time. Loop breaks are arbitrated so that the oldest in-flight iteration wins. The loop then drains and hands control to the entry's true target.

Top module: `ctxseq_top`

## Requirements
- R1: After reset, `ctx_o`, `step_act_o`, `stage_en_o` and `done_o` are all zero, and every table entry reads back as zero.
- R2: A table entry is 25 bits:
  - [3:0] true target
  - [7:4] false target
  - [9:8] condition select
  - [14:10] context
  - [18:15] step vector
  - [20:19] DII-1
  - [22:21] stage count-1
  - [23] loop flag
  - [24] terminal flag

  A running entry that is neither loop nor terminal moves, at the next edge, to the true target if `cond_i[select]` is 1, else to the false target.
- R3: `ctx_o` shows the current entry's context in the cycle right after the edge that made the entry current. `step_act_o` shows the entry's step vector while a plain entry runs, and is zero otherwise.
- R4: A terminal entry is presented for one cycle. The sequencer then halts with `done_o`=1 and `step_act_o`=0, and `ctx_o` keeps the terminal context.
- R5: `cmd_start` (which wins over `cmd_halt`) makes entry 0 current at the next edge and clears `done_o`. `cmd_halt` stops execution without setting `done_o`, and both activation outputs become zero.
- R6: A host write lands only if the sequencer is halted; a write while running leaves the entry unchanged. `host_rdata` always shows the entry at `host_addr`.
- R7: In a loop entry, `ctx_o` equals base context plus a phase that counts 0..DII-1 and wraps. `step_act_o` is zero.
- R8: `stage_en_o` bit i enables stage i+1. Let t be the number of cycles since the loop entry became current, with no break and no stall. The enabled set is then the lowest min(floor(t/DII)+1, stage count) bits.
- R9: While `stall_i` is 1 (and no command or write is given), state and all outputs stay unchanged. Sequencing resumes where it left off.
- R10: `brk_i` bit i is a break request from stage i+1. Among requesting enabled stages, the highest-numbered stage (the oldest iteration) wins. The stages below it are cleared, no new iteration issues, and the stages above it keep shifting until empty. In the cycle after the last one leaves, the true target is current.
- R11: A break request on a stage that is not enabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Table write strobe (halted only) |
| host_addr | input | 4 | Table entry index for write and read |
| host_wdata | input | 25 | Entry to write |
| host_rdata | output | 25 | Entry at `host_addr` |
| cmd_start | input | 1 | Begin at entry 0 |
| cmd_halt | input | 1 | Stop sequencing |
| cond_i | input | 4 | Branch condition flags |
| brk_i | input | 4 | Per-stage loop break requests |
| stall_i | input | 1 | Freeze state transition |
| ctx_o | output | 5 | Active context number |
| step_act_o | output | 4 | Step activation vector |
| stage_en_o | output | 4 | Pipeline stage enables |
| done_o | output | 1 | Terminal entry reached |

## Verification
All outputs are decoded directly from registered state. A wrong state index, phase or stage-valid vector therefore appears on `ctx_o`, `step_act_o` or `stage_en_o` in the very next cycle.

The bench sweeps every combination of DII and stage count. It checks the context and enable pattern cycle by cycle against closed-form formulas.

A wrong break winner shows up one cycle after the request as a different surviving-stage set. A broken drain shows up as the exit context arriving early or late.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;
    parameter int DEPTH   = 16;
    parameter int AW      = $clog2(DEPTH);
    parameter int CTX_W   = 5;
    parameter int STEP_W  = 4;
    parameter int NCOND   = 4;
    parameter int CSEL_W  = $clog2(NCOND);
    parameter int MAX_STG = 4;
    parameter int STG_W   = $clog2(MAX_STG);
    parameter int DII_W   = 2;

    typedef struct packed {
        logic               term;
        logic               loop;
        logic [STG_W-1:0]   nstg_m1;
        logic [DII_W-1:0]   dii_m1;
        logic [STEP_W-1:0]  step;
        logic [CTX_W-1:0]   ctx;
        logic [CSEL_W-1:0]  csel;
        logic [AW-1:0]      nxt_f;
        logic [AW-1:0]      nxt_t;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef struct packed {
        logic [AW-1:0]      state;
        logic               run;
        logic               done;
        logic               drain;
        logic [DII_W-1:0]   phase;
        logic [MAX_STG-1:0] vld;
    } seq_t;
endpackage

// File: rtl/ctxseq_table.sv
module ctxseq_table
    import ctxseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [AW-1:0] raddr_a,
    output entry_t        rd_a,
    input  logic [AW-1:0] raddr_b,
    output entry_t        rd_b,
    input  logic [AW-1:0] raddr_c,
    output logic          loop_c
);
    entry_t rows_q [DEPTH];
    entry_t rows_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rows_d[i] = rows_q[i];
        end
        if (we) begin
            rows_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                rows_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                rows_q[i] <= rows_d[i];
            end
        end
    end

    assign rd_a   = rows_q[raddr_a];
    assign rd_b   = rows_q[raddr_b];
    assign loop_c = rows_q[raddr_c].loop;
endmodule

// File: rtl/ctxseq_brk_arb.sv
module ctxseq_brk_arb
    import ctxseq_pkg::*;
(
    input  logic [MAX_STG-1:0] req,
    output logic               hit,
    output logic [MAX_STG-1:0] keep
);
    // Highest requesting stage (oldest iteration) wins; only stages above it survive.
    always_comb begin
        hit  = 1'b0;
        keep = '1;
        for (int i = 0; i < MAX_STG; i++) begin
            if (req[i]) begin
                hit  = 1'b1;
                keep = {MAX_STG{1'b1}} << (i + 1);
            end
        end
    end
endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
    import ctxseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [AW-1:0]      host_addr,
    input  logic [ENTRY_W-1:0] host_wdata,
    output logic [ENTRY_W-1:0] host_rdata,
    input  logic               cmd_start,
    input  logic               cmd_halt,
    input  logic [NCOND-1:0]   cond_i,
    input  logic [MAX_STG-1:0] brk_i,
    input  logic               stall_i,
    output logic [CTX_W-1:0]   ctx_o,
    output logic [STEP_W-1:0]  step_act_o,
    output logic [MAX_STG-1:0] stage_en_o,
    output logic               done_o
);
    seq_t               seq_q, seq_n, seq_d;
    entry_t             cur, host_ent;
    logic               go;
    logic [AW-1:0]      tgt;
    logic               tgt_loop;
    logic [MAX_STG-1:0] stg_msk, brk_req, keep;
    logic               brk_hit;
    logic               running;

    assign running = seq_q.run;

    ctxseq_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (host_we && !seq_q.run),
        .waddr   (host_addr),
        .wdata   (entry_t'(host_wdata)),
        .raddr_a (seq_q.state),
        .rd_a    (cur),
        .raddr_b (host_addr),
        .rd_b    (host_ent),
        .raddr_c (tgt),
        .loop_c  (tgt_loop)
    );

    assign host_rdata = host_ent;

    for (genvar g = 0; g < MAX_STG; g++) begin : g_msk
        assign stg_msk[g] = (cur.nstg_m1 >= STG_W'(g));
    end

    assign brk_req = brk_i & seq_q.vld & stg_msk & {MAX_STG{!seq_q.drain}};

    ctxseq_brk_arb u_arb (
        .req  (brk_req),
        .hit  (brk_hit),
        .keep (keep)
    );

    // Next-state selection (does not depend on the target's table read).
    always_comb begin
        logic [MAX_STG-1:0] vk, vn;
        logic               dr, wrap;
        seq_n = seq_q;
        go    = 1'b0;
        tgt   = cur.nxt_t;
        vk    = seq_q.vld;
        vn    = seq_q.vld;
        dr    = seq_q.drain;
        wrap  = 1'b0;
        if (cmd_start) begin
            go         = 1'b1;
            tgt        = '0;
            seq_n.run  = 1'b1;
            seq_n.done = 1'b0;
        end else if (cmd_halt) begin
            seq_n.run = 1'b0;
        end else if (seq_q.run && !stall_i) begin
            if (cur.loop) begin
                vk          = brk_hit ? (seq_q.vld & keep) : seq_q.vld;
                dr          = seq_q.drain | brk_hit;
                wrap        = (seq_q.phase == cur.dii_m1);
                seq_n.phase = wrap ? '0 : seq_q.phase + 1'b1;
                vn          = wrap ? ({vk[MAX_STG-2:0], !dr} & stg_msk) : vk;
                seq_n.vld   = vn;
                seq_n.drain = dr;
                if (dr && (vn == '0)) begin
                    go  = 1'b1;
                    tgt = cur.nxt_t;
                end
            end else if (cur.term) begin
                seq_n.run  = 1'b0;
                seq_n.done = 1'b1;
            end else begin
                go  = 1'b1;
                tgt = cond_i[cur.csel] ? cur.nxt_t : cur.nxt_f;
            end
        end
    end

    // Entry setup for the target, using its loop flag.
    always_comb begin
        seq_d = seq_n;
        if (go) begin
            seq_d.state = tgt;
            seq_d.phase = '0;
            seq_d.drain = 1'b0;
            seq_d.vld   = tgt_loop ? MAX_STG'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctx_o      = (seq_q.run && cur.loop) ? (cur.ctx + CTX_W'(seq_q.phase)) : cur.ctx;
    assign step_act_o = (seq_q.run && !cur.loop) ? cur.step : '0;
    assign stage_en_o = (seq_q.run && cur.loop) ? (seq_q.vld & stg_msk) : '0;
    assign done_o     = seq_q.done;
endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk
    import ctxseq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_start,
    input logic               cmd_halt,
    input logic               stall_i,
    input logic               host_we,
    input logic [AW-1:0]      host_addr,
    input logic [ENTRY_W-1:0] host_rdata,
    input logic [CTX_W-1:0]   ctx_o,
    input logic [STEP_W-1:0]  step_act_o,
    input logic [MAX_STG-1:0] stage_en_o,
    input logic               done_o,
    input logic               run_q
);
    p_stall_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stall_i && !cmd_start && !cmd_halt && !host_we) |=>
            ($stable(ctx_o) && $stable(stage_en_o) && $stable(step_act_o)));

    p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (step_act_o == '0 && stage_en_o == '0));

    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !done_o);

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_halt && !cmd_start) |=> (step_act_o == '0 && stage_en_o == '0));

    p_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && host_we && !cmd_start && !cmd_halt) |=>
            ((host_addr != $past(host_addr)) || $stable(host_rdata)));

    p_exclusive_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en_o != '0) |-> (step_act_o == '0));
endmodule

bind ctxseq_top ctxseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_halt   (cmd_halt),
    .stall_i    (stall_i),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .ctx_o      (ctx_o),
    .step_act_o (step_act_o),
    .stage_en_o (stage_en_o),
    .done_o     (done_o),
    .run_q      (running)
);

// File: tb/ctxseq_top_test.sv
module ctxseq_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [3:0]  host_addr;
    logic [24:0] host_wdata;
    logic [24:0] host_rdata;
    logic        cmd_start, cmd_halt;
    logic [3:0]  cond_i, brk_i;
    logic        stall_i;
    logic [4:0]  ctx_o;
    logic [3:0]  step_act_o, stage_en_o;
    logic        done_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxseq_top uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_start(cmd_start),
        .cmd_halt(cmd_halt), .cond_i(cond_i), .brk_i(brk_i), .stall_i(stall_i),
        .ctx_o(ctx_o), .step_act_o(step_act_o), .stage_en_o(stage_en_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(input bit term, input bit lp, input int nstg_m1,
                                       input int dii_m1, input int step, input int ctx,
                                       input int csel, input int nf, input int nt);
        return {term, lp, 2'(nstg_m1), 2'(dii_m1), 4'(step), 5'(ctx), 2'(csel), 4'(nf), 4'(nt)};
    endfunction

    task automatic put(input int addr, input logic [24:0] data);
        host_we = 1'b1; host_addr = 4'(addr); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic start();
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic halt();
        cmd_halt = 1'b1;
        @(negedge clk);
        cmd_halt = 1'b0;
    endtask

    function automatic int fill(input int t, input int d, input int s);
        int n = t / d + 1;
        if (n > s) n = s;
        return (1 << n) - 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_we = 0; host_addr = 0; host_wdata = 0;
        cmd_start = 0; cmd_halt = 0; cond_i = 0; brk_i = 0; stall_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctx", ctx_o, 0);
        chk("R1 step", step_act_o, 0);
        chk("R1 stage", stage_en_o, 0);
        chk("R1 done", done_o, 0);
        host_addr = 4'd9; #1;
        chk("R1 table", host_rdata, 0);

        // R2/R3/R4 exhaustive condition-select sweep
        put(2, mk(1, 0, 0, 0, 2, 10, 0, 0, 0));
        put(3, mk(1, 0, 0, 0, 4, 11, 0, 0, 0));
        for (int c = 0; c < 4; c++) begin
            put(0, mk(0, 0, 0, 0, 1, 4, c, 3, 2));
            for (int f = 0; f < 16; f++) begin
                cond_i = 4'(f);
                start();
                chk("R3 ctx", ctx_o, 4);
                chk("R3 step", step_act_o, 1);
                chk("R5 done cleared", done_o, 0);
                @(negedge clk);
                chk("R2 branch ctx", ctx_o, f[c] ? 10 : 11);
                chk("R3 step after branch", step_act_o, f[c] ? 2 : 4);
                @(negedge clk);
                chk("R4 done", done_o, 1);
                chk("R4 step", step_act_o, 0);
                chk("R4 ctx held", ctx_o, f[c] ? 10 : 11);
            end
        end
        cond_i = 0;

        // R7/R8/R10 sweep over DII and stage count, break on top stage
        put(1, mk(1, 0, 0, 0, 2, 30, 0, 0, 0));
        for (int d = 1; d <= 4; d++) begin
            for (int s = 1; s <= 4; s++) begin
                put(0, mk(0, 1, s - 1, d - 1, 0, 8, 0, 0, 1));
                start();
                for (int t = 0; t <= 12; t++) begin
                    chk("R7 loop ctx", ctx_o, 8 + t % d);
                    chk("R8 stage fill", stage_en_o, fill(t, d, s));
                    chk("R7 step zero", step_act_o, 0);
                    if (t == 12) brk_i = 4'(1 << (s - 1));
                    @(negedge clk);
                end
                brk_i = 0;
                chk("R10 exit ctx", ctx_o, 30);
                chk("R10 exit stage", stage_en_o, 0);
                chk("R10 exit step", step_act_o, 2);
                @(negedge clk);
                chk("R4 done after loop", done_o, 1);
            end
        end

        // R10 priority: stages 1 and 3 request together
        put(0, mk(0, 1, 3, 1, 0, 8, 0, 0, 1));
        start();
        repeat (8) @(negedge clk);
        chk("R8 full", stage_en_o, 15);
        brk_i = 4'b0101;
        @(negedge clk);
        brk_i = 0;
        chk("R10 oldest wins", stage_en_o, 8);
        chk("R10 ctx", ctx_o, 9);
        @(negedge clk);
        chk("R10 exit after drain", ctx_o, 30);

        // R10 drain from a stage-1 break
        start();
        repeat (8) @(negedge clk);
        brk_i = 4'b0001;
        @(negedge clk);
        brk_i = 0;
        chk("R10 drain t9", stage_en_o, 14);
        @(negedge clk);
        chk("R10 drain t10", stage_en_o, 12);
        chk("R10 drain ctx", ctx_o, 8);
        @(negedge clk);
        chk("R10 drain t11", stage_en_o, 12);
        @(negedge clk);
        chk("R10 drain t12", stage_en_o, 8);
        @(negedge clk);
        chk("R10 drain t13", stage_en_o, 8);
        @(negedge clk);
        chk("R10 drained exit", ctx_o, 30);
        chk("R10 drained stage", stage_en_o, 0);

        // R11 break on inactive stage in prologue
        start();
        brk_i = 4'b0100;
        @(negedge clk);
        brk_i = 0;
        chk("R11 ignored", stage_en_o, 1);
        @(negedge clk);
        chk("R11 continues", stage_en_o, 3);
        halt();
        chk("R5 halt stage", stage_en_o, 0);
        chk("R5 halt step", step_act_o, 0);
        chk("R5 halt no done", done_o, 0);

        // R9 stall in loop
        put(0, mk(0, 1, 1, 2, 0, 8, 0, 0, 1));
        start();
        repeat (4) @(negedge clk);
        chk("R9 pre ctx", ctx_o, 9);
        chk("R9 pre stage", stage_en_o, 3);
        stall_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 frozen ctx", ctx_o, 9);
            chk("R9 frozen stage", stage_en_o, 3);
        end
        stall_i = 1'b0;
        @(negedge clk);
        chk("R9 resume ctx", ctx_o, 10);
        chk("R9 resume stage", stage_en_o, 3);
        halt();

        // R6 write while running ignored, while halted accepted
        put(5, 25'h0ABCDE);
        start();
        put(5, 25'h1555555);
        halt();
        host_addr = 4'd5; #1;
        chk("R6 ignored while running", host_rdata, 25'h0ABCDE);
        put(5, 25'h1555555);
        host_addr = 4'd5; #1;
        chk("R6 accepted while halted", host_rdata, 25'h1555555);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule